// File: doc/BRIEF.md
# Serial Decimal-to-Binary Accumulator

This block turns a decimal number into an unsigned binary value. The number arrives one BCD digit per clock cycle, most significant digit first. A single-cycle send strobe marks each digit. On every accepted digit the block multiplies its accumulator by ten and adds the digit. The multiply uses two shifted copies of the accumulator, so no general multiplier is built. The accumulator drives the binary output at all times. When the digits are done, the output holds the converted number.

A digit code above nine is an error, and so is a step whose result would not fit in the accumulator. Either one sets a flag that stays set until reset, and the accumulator keeps its previous value for that step. Later valid digits go on accumulating while the flag stays set. Reset must be applied before each new number is entered.

Top module: `bcd_serial_acc`

## Requirements
- R1: While reset is high at a clock edge, the binary output becomes 0 and the error flag becomes 0 at that edge. Reset takes priority over a send in the same cycle.
- R2: A send with digit d (codes 0000 to 1001) whose result fits causes the output to become ten times its previous value plus d at the next clock edge.
- R3: In a cycle with send low, the digit input has no effect: the output and the error flag keep their values.
- R4: A send with a digit code from 1010 to 1111 sets the error flag at the next edge and leaves the output unchanged.
- R5: A send whose result ten times the output plus d would exceed 65535 sets the error flag and leaves the output unchanged.
- R6: Once set, the error flag stays set until reset. Valid sends made while the flag is set still update the output as in R2.
- R7: Sending the digits 1, 2, 3 after reset gives an output of 123 (binary 1111011).
- R8: A result of exactly 65535, formed from the digits 6, 5, 5, 3, 5, is accepted without error. A digit 9 is accepted, and a digit 10 is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| digit_in | input | 4 | BCD digit to add |
| send | input | 1 | Strobe: take digit_in in this cycle |
| value_out | output | 16 | Accumulated binary value |
| err_out | output | 1 | Sticky error flag |

## Verification
Some properties are checked on every cycle. A cycle with no send must change nothing. An accepted step must equal ten times the old value plus the digit, computed with real multiplication. A rejected step must leave the value alone, and once the flag is set it must stay set. Other behaviours need the bench's digit sequences to show them: the decimal result of a whole run, the exact 65535 boundary against the first value past it, and accumulation going on after an error.

// File: rtl/bcd_acc_pkg.sv
package bcd_acc_pkg;
  localparam int unsigned DIGIT_BITS = 4;
  localparam int unsigned DEC_MAX    = 9;

  // A digit code is decimal when it is at most nine
  function automatic logic is_decimal(input logic [DIGIT_BITS-1:0] code);
    return code <= DIGIT_BITS'(DEC_MAX);
  endfunction
endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
  import bcd_acc_pkg::*;
#(
  parameter int unsigned DIGIT_W = DIGIT_BITS
) (
  input  logic [DIGIT_W-1:0] code_i,
  output logic               decimal_o
);
  always_comb decimal_o = is_decimal(DIGIT_BITS'(code_i));
endmodule

// File: rtl/bcd_mac10.sv
module bcd_mac10 #(
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned DIGIT_W = 4
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [ACC_W-1:0]   sum_o,
  output logic               ovf_o
);
  localparam int unsigned EXT_W = ACC_W + 4;

  // Ten times acc plus digit: two shifted copies of acc and the digit, added in the wide width
  function automatic logic [EXT_W-1:0] times_ten_plus(input logic [ACC_W-1:0] a,
                                                      input logic [DIGIT_W-1:0] d);
    logic [EXT_W-1:0] by8, by2;
    by8 = {1'b0, a, 3'b000};
    by2 = {3'b000, a, 1'b0};
    return by8 + by2 + EXT_W'(d);
  endfunction

  logic [EXT_W-1:0] wide_sum;

  always_comb begin
    wide_sum = times_ten_plus(acc_i, digit_i);
    sum_o    = wide_sum[ACC_W-1:0];
    ovf_o    = |wide_sum[EXT_W-1:ACC_W];
  end
endmodule

// File: rtl/bcd_acc_reg.sv
module bcd_acc_reg #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic             flag_i,
  input  logic [ACC_W-1:0] next_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      err_o <= 1'b0;
    end else begin
      if (take_i) acc_o <= next_i;
      if (flag_i) err_o <= 1'b1;
    end
  end

  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst) err_o |=> err_o);
  // R3
  hold_value_chk: assert property (@(posedge clk) disable iff (rst) !take_i |=> $stable(acc_o));
endmodule

// File: rtl/bcd_serial_acc.sv
module bcd_serial_acc #(
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               send,
  output logic [ACC_W-1:0]   value_out,
  output logic               err_out
);
  logic             digit_ok;
  logic [ACC_W-1:0] mac_sum;
  logic             mac_ovf;
  logic             take_entry;
  logic             flag_entry;

  bcd_digit_check #(.DIGIT_W(DIGIT_W)) u_chk (
    .code_i(digit_in), .decimal_o(digit_ok)
  );

  bcd_mac10 #(.ACC_W(ACC_W), .DIGIT_W(DIGIT_W)) u_mac (
    .acc_i(value_out), .digit_i(digit_in), .sum_o(mac_sum), .ovf_o(mac_ovf)
  );

  always_comb begin
    take_entry = send && digit_ok && !mac_ovf;
    flag_entry = send && (!digit_ok || mac_ovf);
  end

  bcd_acc_reg #(.ACC_W(ACC_W)) u_reg (
    .clk(clk), .rst(rst), .take_i(take_entry), .flag_i(flag_entry),
    .next_i(mac_sum), .acc_o(value_out), .err_o(err_out)
  );

  // R2
  step_value_chk: assert property (@(posedge clk) disable iff (rst)
    take_entry |=> 64'(value_out) == 64'($past(value_out)) * 64'd10 + 64'($past(digit_in)));
  // R4
  bad_digit_chk: assert property (@(posedge clk) disable iff (rst)
    (send && digit_in > DIGIT_W'(9)) |=> (err_out && $stable(value_out)));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (send && 64'(value_out) * 64'd10 + 64'(digit_in) > 64'((64'd1 << ACC_W) - 1))
      |=> (err_out && $stable(value_out)));
  // R3
  idle_err_chk: assert property (@(posedge clk) disable iff (rst)
    !send |=> $stable(err_out));
endmodule

// File: tb/sim_bcd_serial_acc.sv
module sim_bcd_serial_acc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  digit_in = 4'd0;
  logic        send = 1'b0;
  logic [15:0] value_out;
  logic        err_out;
  int          n_run = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  bcd_serial_acc u0 (
    .clk(clk), .rst(rst), .digit_in(digit_in), .send(send),
    .value_out(value_out), .err_out(err_out)
  );

  // row: {rst, send, digit[3:0], expected value[15:0], expected err}
  localparam int NROWS = 25;
  localparam logic [22:0] ROWS [NROWS] = '{
    {1'b1, 1'b0, 4'd0,  16'd0,     1'b0}, // R1 reset
    {1'b0, 1'b1, 4'd1,  16'd1,     1'b0}, // R2
    {1'b0, 1'b1, 4'd2,  16'd12,    1'b0}, // R2
    {1'b0, 1'b1, 4'd3,  16'd123,   1'b0}, // R7
    {1'b0, 1'b0, 4'd5,  16'd123,   1'b0}, // R3 digit ignored
    {1'b0, 1'b1, 4'd0,  16'd1230,  1'b0}, // R2 zero digit
    {1'b1, 1'b0, 4'd0,  16'd0,     1'b0}, // R1
    {1'b0, 1'b1, 4'd6,  16'd6,     1'b0}, // R8
    {1'b0, 1'b1, 4'd5,  16'd65,    1'b0},
    {1'b0, 1'b1, 4'd5,  16'd655,   1'b0},
    {1'b0, 1'b1, 4'd3,  16'd6553,  1'b0},
    {1'b0, 1'b1, 4'd5,  16'd65535, 1'b0}, // R8 exact max
    {1'b0, 1'b1, 4'd0,  16'd65535, 1'b1}, // R5 overflow
    {1'b1, 1'b0, 4'd0,  16'd0,     1'b0}, // R1 clears err
    {1'b0, 1'b1, 4'd12, 16'd0,     1'b1}, // R4 bad code
    {1'b0, 1'b1, 4'd4,  16'd4,     1'b1}, // R6 keeps going
    {1'b0, 1'b0, 4'd9,  16'd4,     1'b1}, // R3
    {1'b0, 1'b1, 4'd7,  16'd47,    1'b1}, // R6
    {1'b1, 1'b0, 4'd0,  16'd0,     1'b0}, // R1
    {1'b0, 1'b1, 4'd6,  16'd6,     1'b0},
    {1'b0, 1'b1, 4'd5,  16'd65,    1'b0},
    {1'b0, 1'b1, 4'd5,  16'd655,   1'b0},
    {1'b0, 1'b1, 4'd3,  16'd6553,  1'b0},
    {1'b0, 1'b1, 4'd6,  16'd6553,  1'b1}, // R5 one past max
    {1'b1, 1'b1, 4'd3,  16'd0,     1'b0}  // R1 reset beats send
  };

  task automatic check(input string tag, input logic [15:0] ev, input logic ee);
    n_run++;
    if (value_out !== ev) begin
      n_fail++;
      $display("FAIL %s value: got %0d expected %0d", tag, value_out, ev);
    end
    n_run++;
    if (err_out !== ee) begin
      n_fail++;
      $display("FAIL %s err: got %0b expected %0b", tag, err_out, ee);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic [3:0] d);
    rst = r; send = s; digit_in = d;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; send = 1'b0;
  endtask

  function automatic logic [16:0] model(input logic [15:0] v, input logic [3:0] d);
    int unsigned t;
    t = int'(v) * 10 + int'(d);
    if (d > 4'd9 || t > 65535) return {1'b1, v};
    return {1'b0, t[15:0]};
  endfunction

  initial begin
    @(negedge clk);
    for (int i = 0; i < NROWS; i++) begin
      step(ROWS[i][22], ROWS[i][21], ROWS[i][20:17]);
      check($sformatf("row%0d R%0d", i, 0), ROWS[i][16:1], ROWS[i][0]);
    end
    // R8 digit boundaries 9 and 10
    step(1'b0, 1'b1, 4'd9);
    check("R8 digit 9", 16'd9, 1'b0);
    step(1'b0, 1'b1, 4'd10);
    check("R8 digit 10", 16'd9, 1'b1);
    step(1'b1, 1'b0, 4'd0);
    check("R1 reset", 16'd0, 1'b0);
    // R2 longer walk against an independent model, including code 15 (R4)
    begin
      logic [15:0] mv;
      logic        me;
      logic [16:0] r;
      mv = 16'd0; me = 1'b0;
      for (int k = 0; k < 12; k++) begin
        logic [3:0] d;
        d = (k == 4) ? 4'd15 : 4'((k * 7 + 3) % 10);
        r = model(mv, d);
        if (r[16]) me = 1'b1; else mv = r[15:0];
        step(1'b0, 1'b1, d);
        check($sformatf("R2 walk %0d", k), mv, me);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule